// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits between the divider outputs of a clock synthesizer and its output drivers. It gates each generated clock so that the output stops or resumes cleanly when a power-down request arrives or is released. It takes a group of single-ended source clocks and a group of differential source clocks. The true phase of each differential source is given, and the complement is its inverse. All source clocks are synchronous to the reference clock `clk` and change between its rising edges. One shared input pin `pwr_pin` serves two purposes in turn. While the block waits for power-good, the pin is an active-low power-good strobe. Once it has been sampled low, the same pin becomes an active-high power-down request.

At power-good the block captures the frequency-select straps and raises the oscillator and PLL enables. It waits for PLL lock and then releases the outputs one at a time. A valid power-down request parks every output at its rest level, and each output parks on its own safe edge. Only after all outputs are parked does the block drop the oscillator and PLL enables. When the request is released, the true phases of the differential outputs are driven high first, and the outputs return after lock. A software run bit stops and resumes a stoppable subset of outputs without runt pulses.

Top module: `clkpd_seq`

## Requirements
- R1: Out of reset the block waits for power-good: while `pwr_pin` is high, `osc_en` and `pll_en` stay 0 and every output stays parked. Once `pwr_pin` is sampled low, the enables rise. After that, a high level on the pin means a power-down request.
- R2: `fsel_stat` takes the value of `fsel_strap` in the cycle power-good is seen. It does not change afterwards while strap inputs change, until the next power-good phase.
- R3: A power-down request is valid only when the synchronized pin is high on two consecutive rising edges of `clk`. A high pulse lasting one cycle has no effect.
- R4: A single-ended output is `se_src & enable`. Its enable changes only at an edge where the source is low, so every output pulse has the full source width. A parked single-ended output is 0.
- R5: A differential enable changes only at an edge where the true source is high, which is the falling phase of the complement. After power-down becomes valid, every output is parked within 4 periods of the slowest source clock.
- R6: A parked pair with `diff_mode` bit 0 drives `dp_t=1`, `dp_t_oe=1` and `dp_c_oe=0`. A parked pair with bit 1 drives `dp_t_oe=0` and `dp_c_oe=0`. A running pair drives both phases with both output enables at 1.
- R7: `osc_en` and `pll_en` fall only after all output enables are 0 and every single-ended output is low.
- R8: Output index i counts the single-ended outputs first, then the differential pairs. An output whose bit in `STOP_MASK` is 1 is stoppable; the default mask 5'b01010 covers single-ended output 1 and pair 0. When `sw_run` is 0 the stoppable outputs park and the others keep running. When `sw_run` is 1 they resume, in both cases without runt pulses.
- R9: After the request is released, the true output of every pair is driven high (`dp_t=1`, `dp_t_oe=1`) while waiting for lock. No output runs before `pll_lock` is 1.
- R10: After lock, one more output index is allowed to run per `clk` cycle, in index order. `all_run` is 1 only when every output is running, so it cannot rise sooner than one cycle per output after lock.
- R11: A reset taken during power-down returns the block to the power-good wait with all outputs parked and the enables at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | active-low asynchronous reset |
| pwr_pin | input | 1 | shared power-good (low) / power-down (high) pin, asynchronous |
| fsel_strap | input | FSW | frequency-select strap inputs |
| sw_run | input | 1 | software run bit for the stoppable group (0 stop, 1 run) |
| diff_mode | input | NDIFF | per-pair parked drive mode |
| se_src | input | NSE | single-ended source clocks |
| diff_src | input | NDIFF | differential source clocks, true phase |
| pll_lock | input | 1 | PLL lock indication |
| se_clk | output | NSE | gated single-ended clocks |
| dp_t | output | NDIFF | differential true output level |
| dp_t_oe | output | NDIFF | differential true output enable |
| dp_c | output | NDIFF | differential complement output level |
| dp_c_oe | output | NDIFF | differential complement output enable |
| fsel_stat | output | FSW | captured strap value |
| osc_en | output | 1 | oscillator enable |
| pll_en | output | 1 | PLL enable |
| all_run | output | 1 | every output is running |

## Verification
An enable register that updates at the wrong phase of its source shows at once as a short high pulse on `se_clk`, or as a short level on a differential phase. The bench measures every high pulse against the source half-period. A faulty synchronizer or sequencer state shows within a few cycles. `osc_en` drops with outputs still toggling, `all_run` stays 0 after lock, or a one-cycle pin pulse parks the outputs. A wrong strap capture or a wrong parked level shows on `fsel_stat` or on the pair output enables as soon as power-good or parking completes.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
    typedef enum logic [2:0] {
        ST_PGWAIT,
        ST_LOCK,
        ST_RAMP,
        ST_RUN,
        ST_PARK,
        ST_OFF
    } seq_st_e;
endpackage

// File: rtl/clkpd_sync.sv
// Two-stage synchronizer for the shared pin plus a history flop that
// qualifies a power-down request over two consecutive samples.
module clkpd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pin_lvl,
    output logic pd_valid
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic hist;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = pin;
        r_d.s2   = r_q.s1;
        r_d.hist = r_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{s1: 1'b1, s2: 1'b1, hist: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pin_lvl  = r_q.s2;
    assign pd_valid = r_q.s2 & r_q.hist;
endmodule

// File: rtl/clkpd_gate.sv
// Enable flop for one output: it follows the request only at an edge
// where the source sits at its safe level.
module clkpd_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic safe,
    input  logic want,
    output logic en
);
    logic en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (safe) begin
            en_d = want;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;
endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
    import clkpd_pkg::*;
#(
    parameter int N   = 5,
    parameter int FSW = 3,
    localparam int AW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pin_lvl,
    input  logic           pd_valid,
    input  logic [FSW-1:0] strap,
    input  logic           pll_lock,
    input  logic [N-1:0]   en_vec,
    output logic [AW-1:0]  allow,
    output seq_st_e        st,
    output logic [FSW-1:0] fsel,
    output logic           osc_en,
    output logic           pll_en,
    output logic           wake_hi,
    output logic           all_run
);
    typedef struct packed {
        seq_st_e        st;
        logic [AW-1:0]  allow;
        logic [FSW-1:0] fsel;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_PGWAIT: begin
                r_d.allow = '0;
                if (!pin_lvl) begin
                    r_d.fsel = strap;
                    r_d.st   = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (pd_valid) begin
                    r_d.st = ST_PARK;
                end else if (pll_lock) begin
                    r_d.st = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (pd_valid) begin
                    r_d.st    = ST_PARK;
                    r_d.allow = '0;
                end else begin
                    r_d.allow = r_q.allow + AW'(1);
                    if (r_q.allow == AW'(N - 1)) begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (pd_valid) begin
                    r_d.st    = ST_PARK;
                    r_d.allow = '0;
                end
            end
            ST_PARK: begin
                if (en_vec == '0) begin
                    r_d.st = ST_OFF;
                end
            end
            ST_OFF: begin
                if (!pin_lvl) begin
                    r_d.st = ST_LOCK;
                end
            end
            default: r_d.st = ST_PGWAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_PGWAIT, allow: '0, fsel: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign allow   = r_q.allow;
    assign st      = r_q.st;
    assign fsel    = r_q.fsel;
    assign osc_en  = (r_q.st == ST_LOCK) || (r_q.st == ST_RAMP) ||
                     (r_q.st == ST_RUN)  || (r_q.st == ST_PARK);
    assign pll_en  = osc_en;
    assign wake_hi = (r_q.st == ST_LOCK) || (r_q.st == ST_RAMP);
    assign all_run = (r_q.st == ST_RUN) && (&en_vec);
endmodule

// File: rtl/clkpd_seq.sv
module clkpd_seq
    import clkpd_pkg::*;
#(
    parameter int NSE   = 3,
    parameter int NDIFF = 2,
    parameter int FSW   = 3,
    parameter logic [NSE+NDIFF-1:0] STOP_MASK = 5'b01010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_pin,
    input  logic [FSW-1:0]   fsel_strap,
    input  logic             sw_run,
    input  logic [NDIFF-1:0] diff_mode,
    input  logic [NSE-1:0]   se_src,
    input  logic [NDIFF-1:0] diff_src,
    input  logic             pll_lock,
    output logic [NSE-1:0]   se_clk,
    output logic [NDIFF-1:0] dp_t,
    output logic [NDIFF-1:0] dp_t_oe,
    output logic [NDIFF-1:0] dp_c,
    output logic [NDIFF-1:0] dp_c_oe,
    output logic [FSW-1:0]   fsel_stat,
    output logic             osc_en,
    output logic             pll_en,
    output logic             all_run
);
    localparam int N  = NSE + NDIFF;
    localparam int AW = $clog2(N + 1);

    logic          pin_lvl;
    logic          pd_valid;
    logic [AW-1:0] allow;
    logic [N-1:0]  want;
    logic [N-1:0]  en;
    logic [N-1:0]  safe;
    logic          wake_hi;
    seq_st_e       st;

    clkpd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (pwr_pin),
        .pin_lvl  (pin_lvl),
        .pd_valid (pd_valid)
    );

    clkpd_fsm #(.N(N), .FSW(FSW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl),
        .pd_valid (pd_valid),
        .strap    (fsel_strap),
        .pll_lock (pll_lock),
        .en_vec   (en),
        .allow    (allow),
        .st       (st),
        .fsel     (fsel_stat),
        .osc_en   (osc_en),
        .pll_en   (pll_en),
        .wake_hi  (wake_hi),
        .all_run  (all_run)
    );

    // Output index order: single-ended first, then differential pairs.
    for (genvar i = 0; i < N; i++) begin : g_want
        assign want[i] = (allow > AW'(i)) && !(STOP_MASK[i] && !sw_run);
    end

    for (genvar i = 0; i < NSE; i++) begin : g_se
        assign safe[i] = !se_src[i];
        clkpd_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .safe  (safe[i]),
            .want  (want[i]),
            .en    (en[i])
        );
        assign se_clk[i] = se_src[i] & en[i];
    end

    for (genvar j = 0; j < NDIFF; j++) begin : g_diff
        logic park_hi;
        assign safe[NSE+j] = diff_src[j];
        clkpd_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .safe  (safe[NSE+j]),
            .want  (want[NSE+j]),
            .en    (en[NSE+j])
        );
        assign park_hi    = wake_hi || !diff_mode[j];
        assign dp_t[j]    = en[NSE+j] ? diff_src[j]  : park_hi;
        assign dp_t_oe[j] = en[NSE+j] | park_hi;
        assign dp_c[j]    = en[NSE+j] & ~diff_src[j];
        assign dp_c_oe[j] = en[NSE+j];
    end
endmodule

// File: rtl/clkpd_seq_chk.sv
module clkpd_seq_chk
    import clkpd_pkg::*;
#(
    parameter int NSE      = 3,
    parameter int NDIFF    = 2,
    parameter int FSW      = 3,
    parameter int PARK_LIM = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_pin,
    input logic [NSE-1:0]         se_src,
    input logic [NDIFF-1:0]       diff_src,
    input logic [NSE-1:0]         se_clk,
    input logic [NSE+NDIFF-1:0]   en,
    input logic [FSW-1:0]         fsel_stat,
    input logic                   osc_en,
    input seq_st_e                st
);
    localparam int CW = $clog2(PARK_LIM + 2);
    logic [CW-1:0] park_cnt;
    logic          in_park;

    assign in_park = (st == ST_PARK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            park_cnt <= '0;
        end else if (!in_park) begin
            park_cnt <= '0;
        end else if (park_cnt <= CW'(PARK_LIM)) begin
            park_cnt <= park_cnt + CW'(1);
        end
    end

    // R4: single-ended enables move only while the source was low
    p_se_safe_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((en[NSE-1:0] ^ $past(en[NSE-1:0])) & $past(se_src)) == '0);

    // R5: differential enables move only while the true source was high
    p_diff_safe_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((en[NSE+NDIFF-1:NSE] ^ $past(en[NSE+NDIFF-1:NSE])) & ~$past(diff_src)) == '0);

    // R5: parking finishes within a bounded window
    p_park_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        park_cnt <= CW'(PARK_LIM));

    // R7: enables fall only with every output parked
    p_osc_after_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> (en == '0) && (se_clk == '0));

    // R3: parking starts only after two high samples of the pin
    p_pd_two_samples_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_park) |-> $past(pwr_pin, 2) && $past(pwr_pin, 3));

    // R2: captured straps hold outside the power-good wait
    p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_PGWAIT) && ($past(st) != ST_PGWAIT) |-> $stable(fsel_stat));
endmodule

bind clkpd_seq clkpd_seq_chk #(.NSE(NSE), .NDIFF(NDIFF), .FSW(FSW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_pin   (pwr_pin),
    .se_src    (se_src),
    .diff_src  (diff_src),
    .se_clk    (se_clk),
    .en        (en),
    .fsel_stat (fsel_stat),
    .osc_en    (osc_en),
    .st        (st)
);

// File: tb/clkpd_seq_tb.sv
module clkpd_seq_tb;
    localparam int NSE = 3, NDIFF = 2, FSW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_pin = 1'b1;
    logic [FSW-1:0] fsel_strap = 3'b101;
    logic sw_run = 1'b1;
    logic [NDIFF-1:0] diff_mode = 2'b10;  // pair0 mode 0, pair1 mode 1
    logic [NSE-1:0] se_src = '0;
    logic [NDIFF-1:0] diff_src = '0;
    logic pll_lock = 1'b0;
    logic [NSE-1:0] se_clk;
    logic [NDIFF-1:0] dp_t, dp_t_oe, dp_c, dp_c_oe;
    logic [FSW-1:0] fsel_stat;
    logic osc_en, pll_en, all_run;

    always #4 clk = ~clk;

    clkpd_seq u_dut (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // Source clocks: half periods of 1,2,3 cycles (single-ended), 1,2 (pairs)
    int cyc = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            se_src[0]   = ~se_src[0];
            if (cyc % 2 == 0) se_src[1] = ~se_src[1];
            if (cyc % 3 == 0) se_src[2] = ~se_src[2];
            diff_src[0] = ~diff_src[0];
            if (cyc % 2 == 0) diff_src[1] = ~diff_src[1];
        end
    end

    // Runt watcher: every single-ended high pulse must last a full half period
    int runts = 0;
    int hi_len [NSE];
    initial begin
        for (int i = 0; i < NSE; i++) hi_len[i] = 0;
        forever begin
            @(posedge clk);
            for (int i = 0; i < NSE; i++) begin
                if (se_clk[i]) hi_len[i]++;
                else begin
                    if (hi_len[i] != 0 && hi_len[i] < i + 1) runts++;
                    hi_len[i] = 0;
                end
            end
        end
    end

    typedef struct {
        string       tag;
        int          sel;
        logic [31:0] exp;
    } item_t;
    item_t sbq[$];
    event  sb_ev;

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0: return 32'(se_clk);
            1: return 32'(dp_t);
            2: return 32'(dp_t_oe);
            3: return 32'(dp_c_oe);
            4: return 32'(fsel_stat);
            5: return 32'({osc_en, pll_en});
            6: return 32'(all_run);
            7: return 32'(runts);
            default: return 32'hdead;
        endcase
    endfunction

    // Monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sb_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sbq.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_now(string tag, int sel, logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sbq.push_back(it);
        ->sb_ev;
        #0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    int lat;
    bit stuck;

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(8);
        // R1 / R11: reset state, waiting for power-good
        expect_now("R1 enables off before power-good", 5, 0);
        expect_now("R11 se parked after reset", 0, 0);
        expect_now("R6 pair0 true oe parked", 2, 32'b01);
        expect_now("R6 complement oe parked", 3, 0);

        // power-good
        @(negedge clk); pwr_pin = 1'b0;
        settle(6);
        expect_now("R1 enables up after power-good", 5, 32'b11);
        expect_now("R2 straps captured", 4, 32'b101);
        expect_now("R9 nothing runs before lock", 6, 0);
        fsel_strap = 3'b010;
        settle(4);
        expect_now("R2 straps held", 4, 32'b101);

        @(negedge clk); pll_lock = 1'b1;
        settle(2);
        expect_now("R10 all_run not immediate after lock", 6, 0);
        settle(20);
        expect_now("R10 all outputs running", 6, 1);
        expect_now("R4 se follows source", 0, 32'(se_src));
        expect_now("R6 running pair true oe", 2, 32'b11);
        expect_now("R6 running pair complement oe", 3, 32'b11);

        // software stop of the stoppable group
        @(negedge clk); sw_run = 1'b0;
        settle(12);
        stuck = 0;
        for (int k = 0; k < 12; k++) begin
            if (se_clk[1] !== 1'b0) stuck = 1;
            settle(1);
        end
        expect_now("R8 stoppable se held low", 7, 0);
        checks++;
        if (stuck) begin errors++; $display("FAIL R8: se1 toggled while stopped, expected low"); end
        expect_now("R8 stopped pair0 complement tri, pair1 running", 3, 32'b10);
        expect_now("R8 all_run drops while stopped", 6, 0);
        expect_now("R8 unstopped se follows source", 0, 32'(se_src & 3'b101));
        @(negedge clk); sw_run = 1'b1;
        settle(16);
        expect_now("R8 resumed", 6, 1);

        // one-cycle pin pulse is ignored
        @(negedge clk); pwr_pin = 1'b1;
        @(negedge clk); pwr_pin = 1'b0;
        settle(10);
        expect_now("R3 single-sample pulse ignored", 6, 1);
        expect_now("R3 enables stay up", 5, 32'b11);

        // real power-down
        @(negedge clk); pwr_pin = 1'b1;
        lat = 0;
        while (!(se_clk == 0 && dp_c_oe == 0 && lat > 3) && lat < 100) begin
            settle(1); lat++;
        end
        checks++;
        if (lat > 28) begin errors++; $display("FAIL R5: park latency %0d expected <= 28", lat); end
        settle(4);
        expect_now("R7 enables dropped after park", 5, 0);
        expect_now("R4 se parked low", 0, 0);
        expect_now("R6 park levels true", 1, 32'b01);
        expect_now("R6 park levels true oe", 2, 32'b01);
        expect_now("R6 park complement oe", 3, 0);
        pll_lock = 1'b0;

        // release
        @(negedge clk); pwr_pin = 1'b0;
        settle(5);
        expect_now("R9 true outputs driven high", 1, 32'b11);
        expect_now("R9 true oe high", 2, 32'b11);
        expect_now("R9 still not running", 6, 0);
        @(negedge clk); pll_lock = 1'b1;
        settle(20);
        expect_now("R9 running after lock", 6, 1);

        // reset during power-down
        @(negedge clk); pwr_pin = 1'b1;
        settle(40);
        pll_lock = 1'b0;
        rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        settle(6);
        expect_now("R11 enables off after reset", 5, 0);
        expect_now("R11 outputs parked after reset", 0, 0);
        expect_now("R11 pair1 tri after reset", 2, 32'b01);
        fsel_strap = 3'b011;
        @(negedge clk); pwr_pin = 1'b0;
        settle(6);
        expect_now("R2 straps recaptured", 4, 32'b011);
        @(negedge clk); pll_lock = 1'b1;
        settle(20);
        expect_now("R10 running again", 6, 1);
        expect_now("R4 no runt pulses seen", 7, 0);

        done = 1;
        finish_run();
    end
endmodule